// File: doc/BRIEF.md
# Shared Timer and Watchdog Divider

This block holds an 8-bit free-running timer, a watchdog counter and one 8-bit binary divider that serves either of them. A single assignment input decides which client the divider serves. While it serves the timer, the divider sits between the timer's clock source and the timer, so the timer advances once per 2 to 256 source events. While it serves the watchdog, the divider stretches the watchdog period by 1 to 128 base wraps, and the timer counts each source event directly. A 3-bit ratio field picks the division, and its meaning depends on the client.

The timer counts either instruction-clock enable pulses or edges of an external pin. The pin passes through a two-stage synchronizer, and a select input picks the rising or the falling edge. The divider itself cannot be read or loaded. It is cleared by the clear action of the client that owns it: a timer write when it serves the timer, and a watchdog clear when it serves the watchdog. It is also cleared whenever the assignment changes, so switching it over can never shorten the first watchdog period.

Top module: `shared_prescale_timer`

## Requirements
- R1: During and right after reset, `tmr_count` is 0x00, `tmr_ovf` is 0 and `wdt_rst` is 0, and the divider and the watchdog base counter are cleared.
- R2: With `div_to_wdt`=0 the timer increments once every 2^(`ratio_sel`+1) source events (ratio_sel 0 gives 1:2, 7 gives 1:256), counting from a cleared divider.
- R3: With `div_to_wdt`=1 the timer increments by one on every source event.
- R4: With `src_ext`=0 a source event is one cycle with `inst_tick`=1. With `src_ext`=1 it is an edge of `ext_pin` after two synchronizer flops: a rising edge when `edge_fall`=0, a falling edge when `edge_fall`=1. `inst_tick` is ignored in that mode.
- R5: `tmr_wr` loads `tmr_wdata` into the timer on the next edge, and the write wins over a same-cycle increment. When `div_to_wdt`=0 the write also clears the divider.
- R6: A count step from 0xFF to 0x00 sets `tmr_ovf`, which stays set until `ovf_clr`; a same-cycle set wins over the clear. A write of 0x00 does not set the flag.
- R7: When `wdt_en`=1 the watchdog base counter wraps every 2^WDT_BITS `wdt_tick` pulses. `wdt_rst` is a one-cycle pulse on the cycle after a wrap for which, if `div_to_wdt`=1, the divider's low `ratio_sel` bits are all ones (ratio 2^ratio_sel). If `div_to_wdt`=0 it pulses on every wrap.
- R8: `wdt_clr` always clears the base counter. It clears the divider only when `div_to_wdt`=1. `tmr_wr` leaves the divider alone when `div_to_wdt`=1.
- R9: Any change of `div_to_wdt` clears the divider, so a divider left at its terminal value by the timer cannot trigger an early watchdog reset.
- R10: With `wdt_en`=0 the base counter holds and `wdt_rst` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_to_wdt | input | 1 | Divider assignment: 0 timer, 1 watchdog |
| ratio_sel | input | 3 | Division ratio select |
| src_ext | input | 1 | Timer source: 0 instruction tick, 1 external pin |
| edge_fall | input | 1 | Pin edge: 0 rising, 1 falling |
| ext_pin | input | 1 | Asynchronous external clock pin |
| inst_tick | input | 1 | Instruction clock enable pulse |
| wdt_tick | input | 1 | Watchdog oscillator tick pulse |
| wdt_en | input | 1 | Watchdog enable |
| tmr_wr | input | 1 | Timer write strobe |
| tmr_wdata | input | 8 | Timer write value |
| wdt_clr | input | 1 | Watchdog clear strobe |
| ovf_clr | input | 1 | Overflow flag clear strobe |
| tmr_count | output | 8 | Timer count value |
| tmr_ovf | output | 1 | Sticky timer overflow flag |
| wdt_rst | output | 1 | Watchdog timeout reset pulse |

## Verification
The assertions assume that `wdt_tick` and `inst_tick` are single-cycle enable pulses and that configuration inputs change only between events. They also assume WDT_BITS is at least 2, so that two resets cannot come on back-to-back cycles. The stimulus drives each tick as a one-cycle pulse on a falling clock edge. It changes configuration only while no tick is pending and toggles `ext_pin` no faster than once every four cycles, so the synchronizer always settles between edges. Random gaps between ticks and random ratio and start values stay within those limits.

// File: rtl/shared_div_pkg.sv
// Package: shared widths and ratio-mask helpers for the shared divider block.
// Assumes the ratio field is 3 bits and the divider 8 bits wide.
package shared_div_pkg;
    localparam int DIV_W = 8;
    localparam int PS_W  = 3;
    localparam int TMR_W = 8;

    // Terminal mask for timer use: low (ps+1) bits set, ratio 2^(ps+1).
    function automatic logic [DIV_W-1:0] tmr_mask(input logic [PS_W-1:0] ps);
        logic [DIV_W:0] m;
        m = ({{DIV_W{1'b0}}, 1'b1} << (ps + 1)) - 1'b1;
        return m[DIV_W-1:0];
    endfunction

    // Terminal mask for watchdog use: low ps bits set, ratio 2^ps.
    function automatic logic [DIV_W-1:0] wdt_mask(input logic [PS_W-1:0] ps);
        logic [DIV_W:0] m;
        m = ({{DIV_W{1'b0}}, 1'b1} << ps) - 1'b1;
        return m[DIV_W-1:0];
    endfunction
endpackage

// File: rtl/sd_edge_sync.sv
// Module: synchronizes an asynchronous pin and emits a one-cycle pulse on
// the selected edge. Assumes the pin is held for at least STAGES+1 cycles.
module sd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic edge_evt
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Shift the pin through the synchronizer and remember the settled level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            last_q <= sync_q[STAGES-1];
        end
    end

    // Pick the rising or falling transition of the settled level.
    always_comb begin
        if (fall_sel) edge_evt = last_q & ~sync_q[STAGES-1];
        else          edge_evt = ~last_q & sync_q[STAGES-1];
    end
endmodule

// File: rtl/sd_wdt_base.sv
// Module: watchdog base counter. Counts oscillator ticks while enabled and
// flags a wrap. A clear wins over a tick in the same cycle.
module sd_wdt_base #(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    input  logic clr,
    output logic wrap
);
    localparam logic [W-1:0] TOP = {W{1'b1}};
    logic [W-1:0] cnt_q;

    // A wrap happens when the last count value receives an enabled tick.
    assign wrap = en & tick & ~clr & (cnt_q == TOP);

    // Advance or clear the base count.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (clr)       cnt_q <= '0;
        else if (en & tick) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/sd_divider.sv
// Module: the shared 8-bit divider. Serves the timer (to_wdt=0) or the
// watchdog (to_wdt=1). It is cleared by its owner's clear action and on any
// change of owner. Assumes the ratio only changes between events.
module sd_divider
    import shared_div_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            to_wdt,
    input  logic [PS_W-1:0] ratio_sel,
    input  logic            src_evt,
    input  logic            wdt_wrap,
    input  logic            tmr_wr,
    input  logic            wdt_clr,
    output logic            tmr_step,
    output logic            wdt_fire
);
    logic [DIV_W-1:0] div_q;
    logic             owner_q;
    logic             stable;
    logic             term_tmr;
    logic             term_wdt;
    logic             owner_clr;

    assign stable   = (to_wdt == owner_q);
    assign term_tmr = (div_q & tmr_mask(ratio_sel)) == tmr_mask(ratio_sel);
    assign term_wdt = (div_q & wdt_mask(ratio_sel)) == wdt_mask(ratio_sel);

    // Route the terminal decode to whichever client owns the divider.
    always_comb begin
        if (to_wdt) begin
            tmr_step = src_evt;
            wdt_fire = wdt_wrap & stable & term_wdt;
        end else begin
            tmr_step = src_evt & stable & term_tmr;
            wdt_fire = wdt_wrap;
        end
    end

    // Clear request from the owning client.
    assign owner_clr = to_wdt ? wdt_clr : tmr_wr;

    // Count the owner's events and clear on owner change or owner clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q   <= '0;
            owner_q <= to_wdt;
        end else begin
            owner_q <= to_wdt;
            if (!stable || owner_clr)        div_q <= '0;
            else if (!to_wdt && src_evt)     div_q <= div_q + 1'b1;
            else if (to_wdt && wdt_wrap)     div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/sd_timer.sv
// Module: 8-bit timer register with a sticky overflow flag. A write wins over
// a step; setting the flag wins over clearing it.
module sd_timer
    import shared_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             wr,
    input  logic [TMR_W-1:0] wdata,
    input  logic             ovf_clr,
    output logic [TMR_W-1:0] count,
    output logic             ovf
);
    logic wrap_now;

    assign wrap_now = step & ~wr & (count == {TMR_W{1'b1}});

    // Load, step or hold the count.
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (wr)   count <= wdata;
        else if (step) count <= count + 1'b1;
    end

    // Keep the overflow flag until software clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)        ovf <= 1'b0;
        else if (wrap_now) ovf <= 1'b1;
        else if (ovf_clr)  ovf <= 1'b0;
    end
endmodule

// File: rtl/shared_prescale_timer.sv
// Module: top level. Selects the timer source, runs the shared divider, the
// timer and the watchdog, and registers the watchdog reset pulse.
// Assumes tick inputs are single-cycle enables in the clk domain.
module shared_prescale_timer
    import shared_div_pkg::*;
#(
    parameter int WDT_BITS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_to_wdt,
    input  logic [PS_W-1:0]  ratio_sel,
    input  logic             src_ext,
    input  logic             edge_fall,
    input  logic             ext_pin,
    input  logic             inst_tick,
    input  logic             wdt_tick,
    input  logic             wdt_en,
    input  logic             tmr_wr,
    input  logic [TMR_W-1:0] tmr_wdata,
    input  logic             wdt_clr,
    input  logic             ovf_clr,
    output logic [TMR_W-1:0] tmr_count,
    output logic             tmr_ovf,
    output logic             wdt_rst
);
    logic pin_evt;
    logic src_evt;
    logic wdt_wrap;
    logic tmr_step;
    logic wdt_fire;

    sd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(ext_pin), .fall_sel(edge_fall),
        .edge_evt(pin_evt)
    );

    // Pick the timer's source event.
    assign src_evt = src_ext ? pin_evt : inst_tick;

    sd_wdt_base #(.W(WDT_BITS)) u_wdt (
        .clk(clk), .rst_n(rst_n), .en(wdt_en), .tick(wdt_tick),
        .clr(wdt_clr), .wrap(wdt_wrap)
    );

    sd_divider u_div (
        .clk(clk), .rst_n(rst_n), .to_wdt(div_to_wdt), .ratio_sel(ratio_sel),
        .src_evt(src_evt), .wdt_wrap(wdt_wrap), .tmr_wr(tmr_wr),
        .wdt_clr(wdt_clr), .tmr_step(tmr_step), .wdt_fire(wdt_fire)
    );

    sd_timer u_tmr (
        .clk(clk), .rst_n(rst_n), .step(tmr_step), .wr(tmr_wr),
        .wdata(tmr_wdata), .ovf_clr(ovf_clr), .count(tmr_count), .ovf(tmr_ovf)
    );

    // Register the watchdog timeout into a one-cycle reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) wdt_rst <= 1'b0;
        else        wdt_rst <= wdt_fire;
    end
endmodule

// File: rtl/shared_prescale_timer_chk.sv
// Checker: temporal properties of the shared divider block, bound to the top.
module shared_prescale_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wdt_tick,
    input logic       wdt_en,
    input logic       tmr_wr,
    input logic [7:0] tmr_wdata,
    input logic       tmr_ovf,
    input logic [7:0] tmr_count,
    input logic       wdt_rst
);
    AST_RST_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |-> $past(wdt_tick && wdt_en)); // R7
    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |=> !wdt_rst); // R7
    AST_NO_RST_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!wdt_en) |-> !wdt_rst); // R10
    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_wr |=> tmr_count == $past(tmr_wdata)); // R5
    AST_COUNT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tmr_wr) && tmr_count != $past(tmr_count))
        |-> tmr_count == $past(tmr_count) + 8'd1); // R2
    AST_WRAP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tmr_wr) && $past(tmr_count) == 8'hFF && tmr_count == 8'h00)
        |-> tmr_ovf); // R6
endmodule

bind shared_prescale_timer shared_prescale_timer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wdt_tick(wdt_tick), .wdt_en(wdt_en),
    .tmr_wr(tmr_wr), .tmr_wdata(tmr_wdata), .tmr_ovf(tmr_ovf),
    .tmr_count(tmr_count), .wdt_rst(wdt_rst)
);

// File: tb/sim_shared_prescale_timer.sv
module sim_shared_prescale_timer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic div_to_wdt = 1'b1, src_ext = 1'b0, edge_fall = 1'b0, ext_pin = 1'b0;
    logic [2:0] ratio_sel = 3'd7;
    logic inst_tick = 1'b0, wdt_tick = 1'b0, wdt_en = 1'b0;
    logic tmr_wr = 1'b0, wdt_clr = 1'b0, ovf_clr = 1'b0;
    logic [7:0] tmr_wdata = 8'h00;
    logic [7:0] tmr_count;
    logic tmr_ovf, wdt_rst;
    int n_tests = 0, n_fail = 0;

    always #5 clk = ~clk;

    shared_prescale_timer u0 (
        .clk(clk), .rst_n(rst_n), .div_to_wdt(div_to_wdt), .ratio_sel(ratio_sel),
        .src_ext(src_ext), .edge_fall(edge_fall), .ext_pin(ext_pin),
        .inst_tick(inst_tick), .wdt_tick(wdt_tick), .wdt_en(wdt_en),
        .tmr_wr(tmr_wr), .tmr_wdata(tmr_wdata), .wdt_clr(wdt_clr),
        .ovf_clr(ovf_clr), .tmr_count(tmr_count), .tmr_ovf(tmr_ovf),
        .wdt_rst(wdt_rst)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected timer value after n events from a cleared divider.
    function automatic int exp_count(input int start, input int n, input int ps);
        return (start + (n >> (ps + 1))) % 256;
    endfunction

    function automatic int exp_flag(input int start, input int n, input int ps);
        return ((start + (n >> (ps + 1))) > 255) ? 1 : 0;
    endfunction

    task automatic inst_pulses(input int n, input bit gaps);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) inst_tick = 1'b1;
            @(negedge clk) inst_tick = 1'b0;
            if (gaps) repeat ($urandom_range(0, 2)) @(negedge clk);
        end
    endtask

    task automatic write_tmr(input logic [7:0] v);
        @(negedge clk) begin tmr_wr = 1'b1; tmr_wdata = v; end
        @(negedge clk) tmr_wr = 1'b0;
    endtask

    task automatic pulse_wclr();
        @(negedge clk) wdt_clr = 1'b1;
        @(negedge clk) wdt_clr = 1'b0;
    endtask

    task automatic toggle_pin();
        @(negedge clk) ext_pin = ~ext_pin;
        repeat (4) @(negedge clk);
    endtask

    task automatic wdt_run(input int n, output int fires, output int first);
        fires = 0; first = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk) wdt_tick = 1'b1;
            @(negedge clk) wdt_tick = 1'b0;
            if (wdt_rst) begin
                fires++;
                if (first == 0) first = i;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int fires, first, start, n, ps;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 count", tmr_count, 0);
        check("R1 flag", tmr_ovf, 0);
        check("R1 wdt_rst", wdt_rst, 0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check("R1 count after release", tmr_count, 0);

        // R2: timer owns the divider
        @(negedge clk) begin div_to_wdt = 1'b0; ratio_sel = 3'd0; end
        write_tmr(8'h00);
        inst_pulses(5, 0);
        check("R2 ratio 1:2", tmr_count, 2);
        @(negedge clk) ratio_sel = 3'd7;
        write_tmr(8'h00);
        inst_pulses(255, 0);
        check("R2 ratio 1:256 before", tmr_count, 0);
        inst_pulses(1, 0);
        check("R2 ratio 1:256 at", tmr_count, 1);

        // R3: watchdog owns the divider, timer undivided
        @(negedge clk) div_to_wdt = 1'b1;
        write_tmr(8'h00);
        inst_pulses(10, 1);
        check("R3 undivided", tmr_count, 10);

        // R5: write wins over a same-cycle step
        @(negedge clk) begin tmr_wr = 1'b1; tmr_wdata = 8'h40; inst_tick = 1'b1; end
        @(negedge clk) begin tmr_wr = 1'b0; inst_tick = 1'b0; end
        check("R5 write wins", tmr_count, 8'h40);
        // R5: write clears the divider when the timer owns it
        @(negedge clk) begin div_to_wdt = 1'b0; ratio_sel = 3'd1; end
        write_tmr(8'h00);
        inst_pulses(3, 0);
        write_tmr(8'h10);
        inst_pulses(3, 0);
        check("R5 divider cleared", tmr_count, 8'h10);
        inst_pulses(1, 0);
        check("R5 step after clear", tmr_count, 8'h11);

        // R6: overflow flag
        @(negedge clk) div_to_wdt = 1'b1;
        write_tmr(8'hFE);
        inst_pulses(1, 0);
        check("R6 no flag at FF", tmr_ovf, 0);
        inst_pulses(1, 0);
        check("R6 wrap value", tmr_count, 0);
        check("R6 flag set", tmr_ovf, 1);
        inst_pulses(1, 0);
        check("R6 flag sticky", tmr_ovf, 1);
        @(negedge clk) ovf_clr = 1'b1;
        @(negedge clk) ovf_clr = 1'b0;
        check("R6 flag cleared", tmr_ovf, 0);
        write_tmr(8'hFF);
        @(negedge clk) begin inst_tick = 1'b1; ovf_clr = 1'b1; end
        @(negedge clk) begin inst_tick = 1'b0; ovf_clr = 1'b0; end
        check("R6 set wins", tmr_ovf, 1);
        @(negedge clk) ovf_clr = 1'b1;
        @(negedge clk) ovf_clr = 1'b0;
        write_tmr(8'hFF);
        write_tmr(8'h00);
        check("R6 write no flag", tmr_ovf, 0);

        // R4: external pin source
        @(negedge clk) begin src_ext = 1'b1; edge_fall = 1'b0; end
        write_tmr(8'h00);
        toggle_pin();
        check("R4 rising counted", tmr_count, 1);
        toggle_pin();
        check("R4 falling ignored", tmr_count, 1);
        inst_pulses(3, 0);
        check("R4 inst_tick ignored", tmr_count, 1);
        @(negedge clk) edge_fall = 1'b1;
        toggle_pin();
        check("R4 rising ignored in fall mode", tmr_count, 1);
        toggle_pin();
        check("R4 falling counted", tmr_count, 2);
        @(negedge clk) src_ext = 1'b0;

        // R7: watchdog timeout with divider ratio 1:4
        @(negedge clk) begin wdt_en = 1'b1; div_to_wdt = 1'b1; ratio_sel = 3'd2; end
        pulse_wclr();
        wdt_run(1024, fires, first);
        check("R7 ratio 4 fires", fires, 1);
        check("R7 ratio 4 tick", first, 1024);
        @(negedge clk) div_to_wdt = 1'b0;
        pulse_wclr();
        wdt_run(256, fires, first);
        check("R7 undivided tick", first, 256);

        // R10: disabled watchdog
        @(negedge clk) wdt_en = 1'b0;
        pulse_wclr();
        wdt_run(300, fires, first);
        check("R10 no reset disabled", fires, 0);
        @(negedge clk) wdt_en = 1'b1;

        // R8: timer write leaves watchdog-owned divider alone
        @(negedge clk) begin div_to_wdt = 1'b1; ratio_sel = 3'd1; end
        pulse_wclr();
        wdt_run(256, fires, first);
        check("R8 first half quiet", fires, 0);
        write_tmr(8'h00);
        wdt_run(256, fires, first);
        check("R8 tmr_wr keeps divider", first, 256);
        // R8: watchdog clear clears the owned divider
        pulse_wclr();
        wdt_run(300, fires, first);
        pulse_wclr();
        wdt_run(511, fires, first);
        check("R8 clear restarts", fires, 0);
        wdt_run(1, fires, first);
        check("R8 fires after full period", fires, 1);
        // R8: watchdog clear leaves timer-owned divider alone
        @(negedge clk) div_to_wdt = 1'b0;
        write_tmr(8'h00);
        inst_pulses(2, 0);
        pulse_wclr();
        inst_pulses(2, 0);
        check("R8 wdt_clr keeps timer divider", tmr_count, 1);

        // R9: switch timer to watchdog with divider at all ones
        @(negedge clk) ratio_sel = 3'd7;
        write_tmr(8'h00);
        inst_pulses(255, 0);
        pulse_wclr();
        @(negedge clk) begin div_to_wdt = 1'b1; ratio_sel = 3'd3; end
        wdt_run(2047, fires, first);
        check("R9 no early reset", fires, 0);
        wdt_run(1, fires, first);
        check("R9 reset at full period", fires, 1);

        // R2/R6 random: random ratio, start and event count
        @(negedge clk) begin wdt_en = 1'b0; div_to_wdt = 1'b0; end
        for (int k = 0; k < 8; k++) begin
            ps = $urandom_range(0, 7);
            start = $urandom_range(0, 255);
            n = $urandom_range(0, 700);
            @(negedge clk) begin ratio_sel = ps[2:0]; ovf_clr = 1'b1; end
            @(negedge clk) ovf_clr = 1'b0;
            write_tmr(start[7:0]);
            inst_pulses(n, 1);
            check("R2 random count", tmr_count, exp_count(start, n, ps));
            check("R6 random flag", tmr_ovf, exp_flag(start, n, ps));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule